// File: doc/BRIEF.md
# SMBus Register Target with Grouped Block Reads

This block is a bus target for a two-wire system management bus. It sits between the oversampled bus lines and an 8-bit indexed register file and turns bus transactions into register accesses. The block supports single-byte reads and writes, a counted block write and a block write/read process call. A set of reserved command codes reads a whole register group: each one loads a fixed first register and byte count, and a single transaction then streams the group.

The 7-bit bus address has two parts. The upper five bits are a parameter. The lower two bits come from a board strap, which reaches the block as a 2-bit code and allows three addresses. Writes leave the block as a single-cycle strobe that carries an index and data. Reads use a combinational port. A free-running prescaled counter watches for a line held low and returns the interface to idle when the hold lasts too long. The default tick values give about 30 ms at a 50 MHz clock.

Top module: `smb_regslave`

## Requirements
- R1: The target acknowledges only the 7-bit address {ADDR_HI, addr_sel} with addr_sel in 0..2. When addr_sel is 3, or for any other address, there is no acknowledge and no register activity.
- R2: A write with command 00h..EFh sets the pointer to the command value. Each following data byte is acknowledged and written to consecutive indices, with one reg_we pulse per byte.
- R3: A write with command 00h..EFh, then a repeated START and a read, returns the register at the command index. Each master ACK advances the pointer by one before the next byte is fetched.
- R4: Command F0h takes a first-index byte, a count byte and then count data bytes, which are written to consecutive indices. A data byte beyond the count is NACKed and is not written.
- R5: For F0h and F1h, a count of 0 or a count above 32 is NACKed.
- R6: Command F1h writes as in R4. A following repeated-START read returns the count first, then the bytes from the first index onward.
- R7: Commands F2h..FDh map to first index and count as follows: F2h 40h/8, F3h 48h/8, F4h 50h/6, F5h 56h/16, F6h 67h/4, F7h 6Eh/8, F8h 78h/12, F9h 90h/32, FAh B4h/8, FBh C8h/8, FCh D0h/16, FDh E5h/9. A read returns the count, then the registers from the first index. Data bytes written after such a command are NACKed.
- R8: Command bytes FEh and FFh are NACKed and cause no write.
- R9: A master NACK ends a read. The target releases SDA and drives no further bits.
- R10: A STOP or repeated START during a byte discards that byte with no write. After a repeated START, the pointer from the earlier command is kept.
- R11: If SCL or SDA stays low with no line change for TOUT_TICKS prescaler periods of PRESCALE clocks, the target returns to idle and releases SDA. This does not happen before (TOUT_TICKS-1)*PRESCALE clocks.
- R12: reg_we is never high on two consecutive cycles.
- R13: SDA is never driven while the target is idle, including out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_sel | input | 2 | Digitised strap code for the low address bits (3 = no address) |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | High pulls the data line low |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_waddr | output | 8 | Write index |
| reg_wdata | output | 8 | Write data |
| reg_raddr | output | 8 | Read index (current pointer) |
| reg_rdata | input | 8 | Combinational read data for reg_raddr |

## Verification
The hardest situation to reach from the ports is the timeout window. The bench has to stall the bus at a point where the target itself holds SDA low, and then show both that SDA stays driven just before the threshold and that it is released just after it. To get there, the bench sends an address byte and freezes SCL low during the acknowledge bit. It uses a small prescaler so the window is a few hundred cycles, and samples sda_oe on each side of the window before restarting the bus. The per-clock write comparison also catches aborted bytes and over-count block data. Any stray strobe in those cases finds no matching entry in the expected queue.

// File: rtl/smb_regslave.sv
module smb_regslave #(
  parameter logic [4:0] ADDR_HI    = 5'b01001,
  parameter int         PRESCALE   = 50000,
  parameter int         TOUT_TICKS = 30,
  parameter int         MAX_BLK    = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr_sel,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic       reg_we,
  output logic [7:0] reg_waddr,
  output logic [7:0] reg_wdata,
  output logic [7:0] reg_raddr,
  input  logic [7:0] reg_rdata
);
  localparam int PW = $clog2(PRESCALE + 1);
  localparam int TW = $clog2(TOUT_TICKS + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(PRESCALE - 1);
  localparam logic [TW-1:0] TLIM     = TW'(TOUT_TICKS);
  localparam logic [7:0]    MAXB     = 8'(MAX_BLK);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACK, S_TX, S_MACK} st_t;
  typedef enum logic [2:0] {K_ADDR, K_CMD, K_BASE, K_COUNT, K_DATA} kind_t;
  typedef enum logic [1:0] {M_PLAIN, M_BLK, M_PROC, M_FIXED} mode_t;

  function automatic logic [15:0] grp_map(input logic [7:0] c);
    case (c)
      8'hF2: return {8'h40, 8'd8};
      8'hF3: return {8'h48, 8'd8};
      8'hF4: return {8'h50, 8'd6};
      8'hF5: return {8'h56, 8'd16};
      8'hF6: return {8'h67, 8'd4};
      8'hF7: return {8'h6E, 8'd8};
      8'hF8: return {8'h78, 8'd12};
      8'hF9: return {8'h90, 8'd32};
      8'hFA: return {8'hB4, 8'd8};
      8'hFB: return {8'hC8, 8'd8};
      8'hFC: return {8'hD0, 8'd16};
      8'hFD: return {8'hE5, 8'd9};
      default: return 16'h0000;
    endcase
  endfunction

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  wire scl_s = scl_sy[1];
  wire sda_s = sda_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;

  logic [PW-1:0] pre;
  logic [TW-1:0] lowcnt;
  wire tick     = (pre == PRE_LAST);
  wire line_chg = (scl_s != scl_q) | (sda_s != sda_q);
  wire tmo      = (lowcnt == TLIM);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre <= '0; lowcnt <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (line_chg || (scl_s && sda_s)) lowcnt <= '0;
      else if (tick && !tmo)            lowcnt <= lowcnt + 1'b1;
    end

  st_t        state;
  kind_t      kind, nxt_kind;
  mode_t      mode;
  logic       armed, ack_q, go_tx, cnt_phase;
  logic [3:0] bitcnt;
  logic [7:0] sh, ptr, base, len, rem;

  wire [7:0]  rx_byte = {sh[6:0], sda_s};
  wire [7:0]  tx_next = cnt_phase ? len : reg_rdata;
  wire [15:0] gm      = grp_map(rx_byte);
  assign reg_raddr = ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; kind <= K_ADDR; nxt_kind <= K_ADDR; mode <= M_PLAIN;
      armed <= 1'b0; ack_q <= 1'b0; go_tx <= 1'b0; cnt_phase <= 1'b0;
      bitcnt <= '0; sh <= '0; ptr <= '0; base <= '0; len <= '0; rem <= '0;
      sda_oe <= 1'b0; reg_we <= 1'b0; reg_waddr <= '0; reg_wdata <= '0;
    end else begin
      reg_we <= 1'b0;
      if (tmo) begin
        state <= S_IDLE; sda_oe <= 1'b0; armed <= 1'b0;
      end else if (start_c) begin
        state <= S_RX; kind <= K_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        state <= S_IDLE; sda_oe <= 1'b0; armed <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              sh     <= rx_byte;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == 4'd7) begin
                case (kind)
                  K_ADDR: begin
                    if (addr_sel != 2'd3 && rx_byte[7:1] == {ADDR_HI, addr_sel}) begin
                      ack_q <= 1'b1;
                      go_tx <= rx_byte[0];
                      if (rx_byte[0]) begin
                        cnt_phase <= armed && (mode == M_PROC || mode == M_FIXED);
                        armed     <= 1'b0;
                        if (armed && mode == M_PROC) ptr <= base;
                      end else nxt_kind <= K_CMD;
                    end else begin
                      ack_q <= 1'b0;
                      state <= S_IDLE;
                    end
                  end
                  K_CMD: begin
                    go_tx <= 1'b0;
                    if (rx_byte >= 8'hFE) ack_q <= 1'b0;
                    else begin
                      ack_q <= 1'b1;
                      armed <= 1'b1;
                      if (rx_byte == 8'hF0) begin
                        mode <= M_BLK; nxt_kind <= K_BASE;
                      end else if (rx_byte == 8'hF1) begin
                        mode <= M_PROC; nxt_kind <= K_BASE;
                      end else if (rx_byte >= 8'hF2) begin
                        mode <= M_FIXED; ptr <= gm[15:8]; len <= gm[7:0]; nxt_kind <= K_DATA;
                      end else begin
                        mode <= M_PLAIN; ptr <= rx_byte; nxt_kind <= K_DATA;
                      end
                    end
                  end
                  K_BASE: begin
                    ack_q <= 1'b1; ptr <= rx_byte; base <= rx_byte; nxt_kind <= K_COUNT;
                  end
                  K_COUNT: begin
                    ack_q <= (rx_byte != 8'd0) && (rx_byte <= MAXB);
                    len <= rx_byte; rem <= rx_byte; nxt_kind <= K_DATA;
                  end
                  default: begin
                    if (mode == M_PLAIN || ((mode == M_BLK || mode == M_PROC) && rem != 8'd0)) begin
                      ack_q <= 1'b1;
                      reg_we <= 1'b1; reg_waddr <= ptr; reg_wdata <= rx_byte;
                      ptr <= ptr + 1'b1;
                      if (mode != M_PLAIN) rem <= rem - 1'b1;
                    end else ack_q <= 1'b0;
                  end
                endcase
              end
            end else if (scl_fall && bitcnt == 4'd8) begin
              sda_oe <= ack_q;
              state  <= S_ACK;
            end
          end
          S_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            if (!ack_q) state <= S_IDLE;
            else if (go_tx) begin
              state <= S_TX; sh <= tx_next; sda_oe <= ~tx_next[7];
            end else begin
              state <= S_RX; kind <= nxt_kind;
            end
          end
          S_TX: begin
            if (scl_rise) bitcnt <= bitcnt + 1'b1;
            else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0; state <= S_MACK;
              end else sda_oe <= ~sh[3'(4'd7 - bitcnt)];
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              if (sda_s) state <= S_IDLE;
              else if (cnt_phase) cnt_phase <= 1'b0;
              else ptr <= ptr + 1'b1;
            end else if (scl_fall) begin
              state <= S_TX; bitcnt <= '0; sh <= tx_next; sda_oe <= ~tx_next[7];
            end
          end
          default: ;
        endcase
      end
    end

  p_we_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_oe);
  p_count_ok_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ACK && kind == K_COUNT && ack_q) |-> (len != 8'd0 && len <= MAXB));
  p_grp_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (mode != M_FIXED));
  p_blk_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RX && kind == K_DATA && (mode == M_BLK || mode == M_PROC) &&
     scl_rise && bitcnt == 4'd7 && rem == 8'd0) |=> !reg_we);
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c && !tmo) |=> (state == S_RX && bitcnt == 4'd0 && !sda_oe));
  p_tmo_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> (state == S_IDLE && !sda_oe));
endmodule

// File: tb/smb_regslave_tb_top.sv
module smb_regslave_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] sel = 2'd2;
  logic       sda_oe, reg_we;
  logic [7:0] reg_waddr, reg_wdata, reg_raddr;
  logic [7:0] mem [256];
  wire        sda_line  = sda_m & ~sda_oe;
  wire  [7:0] reg_rdata = mem[reg_raddr];

  int errors = 0, checks = 0;
  logic [15:0] wq[$];
  bit done = 1'b0;

  localparam logic [7:0] AW = 8'h4C, AR = 8'h4D;

  smb_regslave #(.PRESCALE(10), .TOUT_TICKS(30)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_sel(sel), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      checks++;
      if (wq.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected write actual=%0h:%0h expected=none", reg_waddr, reg_wdata);
      end else begin
        logic [15:0] e;
        e = wq.pop_front();
        if ({reg_waddr, reg_wdata} !== e) begin
          errors++;
          $display("FAIL R2 write actual=%0h expected=%0h", {reg_waddr, reg_wdata}, e);
        end
      end
      mem[reg_waddr] = reg_wdata;
    end
  end

  task automatic q(); repeat (10) @(negedge clk); endtask
  task automatic b_start(); sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q(); endtask
  task automatic b_stop(); sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); endtask

  task automatic send(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
    end
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = ~sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic recv(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; q(); scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0; q();
    end
    sda_m = ~give_ack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q(); sda_m = 1'b1;
  endtask

  task automatic sendc(input string req, input logic [7:0] b, input bit exp_ack);
    bit a;
    send(b, a);
    chk(req, a, exp_ack);
  endtask

  task automatic recvc(input string req, input bit give_ack, input logic [7:0] exp);
    logic [7:0] b;
    recv(give_ack, b);
    chk(req, b, exp);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R13 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'hA5;
    repeat (5) @(negedge clk);
    chk("R13 reset sda_oe", sda_oe, 0);
    chk("R12 reset reg_we", reg_we, 0);
    rst_n = 1'b1;
    q();

    // R1/R2 plain write, two bytes
    b_start(); sendc("R1 own address", AW, 1); sendc("R2 cmd", 8'h12, 1);
    wq.push_back({8'h12, 8'h3C}); sendc("R2 data0", 8'h3C, 1);
    wq.push_back({8'h13, 8'h3D}); sendc("R2 data1", 8'h3D, 1);
    b_stop(); q();
    chk("R2 writes drained", wq.size(), 0);

    // R3 read with increment, R9 release after NACK
    b_start(); sendc("R3 addr", AW, 1); sendc("R3 cmd", 8'h12, 1);
    b_start(); sendc("R3 read addr", AR, 1);
    recvc("R3 byte0", 1, 8'h3C); recvc("R3 byte1 increments", 0, 8'h3D);
    scl_m = 1'b1; q(); chk("R9 released high", sda_oe, 0); q();
    scl_m = 1'b0; q(); q(); chk("R9 released low", sda_oe, 0);
    b_stop(); q();

    // R1 address select
    sel = 2'd3; b_start(); sendc("R1 code3 no ack", AW, 0); b_stop(); q();
    sel = 2'd2; b_start(); sendc("R1 other addr no ack", 8'h48, 0); b_stop(); q();
    sel = 2'd0; b_start(); sendc("R1 code0 ack", 8'h48, 1); b_stop(); q();
    sel = 2'd2;

    // R4 block write with overrun
    b_start(); sendc("R4 addr", AW, 1); sendc("R4 cmd", 8'hF0, 1);
    sendc("R4 first", 8'h20, 1); sendc("R4 count", 8'h02, 1);
    wq.push_back({8'h20, 8'hAA}); sendc("R4 d0", 8'hAA, 1);
    wq.push_back({8'h21, 8'hBB}); sendc("R4 d1", 8'hBB, 1);
    sendc("R4 overrun nack", 8'hCC, 0);
    b_stop(); q();
    chk("R4 mem untouched past count", mem[8'h22], 8'h22 ^ 8'hA5);

    // R5 count range
    b_start(); sendc("R5 addr", AW, 1); sendc("R5 cmd", 8'hF0, 1); sendc("R5 first", 8'h20, 1);
    sendc("R5 zero count nack", 8'h00, 0); b_stop(); q();
    b_start(); sendc("R5 addr", AW, 1); sendc("R5 cmd", 8'hF1, 1); sendc("R5 first", 8'h20, 1);
    sendc("R5 count 33 nack", 8'd33, 0); b_stop(); q();
    b_start(); sendc("R5 addr", AW, 1); sendc("R5 cmd", 8'hF0, 1); sendc("R5 first", 8'h20, 1);
    sendc("R5 count 32 ack", 8'd32, 1); b_stop(); q();

    // R6 process call
    b_start(); sendc("R6 addr", AW, 1); sendc("R6 cmd", 8'hF1, 1);
    sendc("R6 first", 8'h30, 1); sendc("R6 count", 8'h03, 1);
    wq.push_back({8'h30, 8'h11}); sendc("R6 d0", 8'h11, 1);
    wq.push_back({8'h31, 8'h22}); sendc("R6 d1", 8'h22, 1);
    wq.push_back({8'h32, 8'h33}); sendc("R6 d2", 8'h33, 1);
    b_start(); sendc("R6 read addr", AR, 1);
    recvc("R6 count back", 1, 8'h03); recvc("R6 r0", 1, 8'h11);
    recvc("R6 r1", 1, 8'h22); recvc("R6 r2", 0, 8'h33);
    b_stop(); q();

    // R7 grouped reads
    b_start(); sendc("R7 addr", AW, 1); sendc("R7 cmd F5", 8'hF5, 1);
    b_start(); sendc("R7 read addr", AR, 1);
    recvc("R7 F5 count", 1, 8'd16);
    for (int i = 0; i < 16; i++) recvc("R7 F5 data", i != 15, mem[8'h56 + i]);
    b_stop(); q();
    b_start(); sendc("R7 addr", AW, 1); sendc("R7 cmd FD", 8'hFD, 1);
    b_start(); sendc("R7 read addr", AR, 1);
    recvc("R7 FD count", 1, 8'd9); recvc("R7 FD d0", 1, mem[8'hE5]); recvc("R7 FD d1", 0, mem[8'hE6]);
    b_stop(); q();
    b_start(); sendc("R7 addr", AW, 1); sendc("R7 cmd F9", 8'hF9, 1);
    b_start(); sendc("R7 read addr", AR, 1);
    recvc("R7 F9 count", 1, 8'd32); recvc("R7 F9 d0", 0, mem[8'h90]);
    b_stop(); q();
    b_start(); sendc("R7 addr", AW, 1); sendc("R7 cmd F3", 8'hF3, 1);
    sendc("R7 write after group nack", 8'h77, 0); b_stop(); q();

    // R8 reserved commands
    b_start(); sendc("R8 addr", AW, 1); sendc("R8 FE nack", 8'hFE, 0); b_stop(); q();
    b_start(); sendc("R8 addr", AW, 1); sendc("R8 FF nack", 8'hFF, 0); b_stop(); q();

    // R10 abort by STOP and by repeated START
    b_start(); sendc("R10 addr", AW, 1); sendc("R10 cmd", 8'h40, 1);
    for (int i = 7; i >= 4; i--) begin sda_m = 1'b1; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q(); end
    b_stop(); q();
    chk("R10 no write on stop abort", mem[8'h40], 8'h40 ^ 8'hA5);
    b_start(); sendc("R10 addr", AW, 1); sendc("R10 cmd", 8'h41, 1);
    for (int i = 7; i >= 5; i--) begin sda_m = 1'b0; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q(); end
    b_start(); sendc("R10 read addr", AR, 1); recvc("R10 pointer kept", 0, mem[8'h41]);
    b_stop(); q();
    chk("R10 no pending writes", wq.size(), 0);

    // R11 timeout during the address acknowledge
    b_start();
    for (int i = 7; i >= 0; i--) begin sda_m = AW[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q(); end
    sda_m = 1'b1; repeat (5) @(negedge clk);
    chk("R11 ack driven", sda_oe, 1);
    repeat (245) @(negedge clk);
    chk("R11 held before threshold", sda_oe, 1);
    repeat (110) @(negedge clk);
    chk("R11 released after threshold", sda_oe, 0);
    scl_m = 1'b1; q(); q();
    b_start(); sendc("R11 recovery addr", AW, 1); sendc("R11 recovery cmd", 8'h50, 1);
    wq.push_back({8'h50, 8'h9E}); sendc("R11 recovery data", 8'h9E, 1);
    b_stop(); q();

    chk("R2 all expected writes seen", wq.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule